// File: doc/BRIEF.md
# Undervoltage Fault Supervisor with Automatic Retry

This block watches four digitized undervoltage comparator flags: the logic regulator's input supply, the logic regulator's output, the sense-amplifier reference and the charge pump. From these flags it decides which parts of a motor-driver die stay enabled. The outputs it controls are the power stage, the charge pump, the current-sense amplifiers and the serial interface. It drives an active-low fault pin, exposes one live status bit per source, and holds two sticky summary bits: a global fault bit and an undervoltage summary bit.

Each source runs its own retry timer. When a flag drops, the timer counts for a recovery period. Once the period has elapsed, the functions that source had shut down come back without any action from the host, and its status bit clears. The sticky bits stay set until the host clears them, either with a clear-fault pulse or by taking the sleep input low and then high again. The recovery period is chosen by a 3-bit mode field, slow or fast. A fixed-configuration strap forces the fast period and keeps the reference monitor off.

Top module: `uv_supervisor`

## Requirements
- R1: After reset, `fault_n`, `pwr_en`, `cp_en`, `csa_en` and `ser_en` are 1, and `src_status`, `fault_sticky` and `uv_sticky` are 0.
- R2: The reference flag (`uv_flag[2]`) has no effect unless `ref_mon_en` is 1 and `fixed_cfg` is 0. The other three flags are always monitored.
- R3: While the regulator-input source (`uv_flag[0]`, `src_status[0]`) or the regulator-output source (`uv_flag[1]`, `src_status[1]`) is active, `pwr_en` and `ser_en` are 0.
- R4: While the charge-pump source (`uv_flag[3]`, `src_status[3]`) is active, `pwr_en` and `cp_en` are 0. While the reference source is active, only `csa_en` is 0.
- R5: `fault_n` is 0 while any source is active. A source is active from the time its flag is seen until its retry period completes.
- R6: `src_status[i]` is 1 exactly while source i is active, and it clears by itself when its retry completes.
- R7: `fault_sticky` and `uv_sticky` set on any active source. They hold after recovery. They clear on a `clr_fault` pulse or on a rising edge of `sleep_n`. A source that is still active overrides the clear.
- R8: A source stops being active after its flag has been seen low for P consecutive cycles. P is FAST_CYC when `retry_mode` is 3'b001. P is SLOW_CYC when `retry_mode` is 3'b000 or any other code.
- R9: When `fixed_cfg` is 1, P is FAST_CYC whatever `retry_mode` holds.
- R10: A flag that reasserts while its retry timer runs restarts that timer, so a full P low cycles are needed after the last low-going edge.
- R11: Flags pass through a two-stage synchronizer. A flag change shows at the outputs on the fourth rising edge after it, and release comes P+3 edges after the flag falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_flag | input | 4 | Comparator flags: 0 regulator input, 1 regulator output, 2 reference, 3 charge pump |
| ref_mon_en | input | 1 | Enables action on the reference flag |
| fixed_cfg | input | 1 | Fixed-configuration strap: fast retry, reference monitor off |
| retry_mode | input | 3 | Retry period select (001 fast, anything else slow) |
| clr_fault | input | 1 | Pulse that clears the sticky bits |
| sleep_n | input | 1 | Sleep input; its rising edge clears the sticky bits |
| pwr_en | output | 1 | Power stage enable |
| cp_en | output | 1 | Charge pump enable |
| csa_en | output | 1 | Sense amplifier enable |
| ser_en | output | 1 | Serial interface enable |
| fault_n | output | 1 | Active-low fault pin |
| src_status | output | 4 | Live per-source status |
| fault_sticky | output | 1 | Latched global fault |
| uv_sticky | output | 1 | Latched undervoltage summary |

## Verification
A flag change reaches the outputs on the fourth rising edge: two edges go to the synchronizer, one to the channel state and one to the output register. Release comes P+3 edges after the flag goes low. Clear-fault and the sleep edge act on the very next edge. The bench drives inputs on falling edges and samples every output on the following falling edge. It checks each output against a cycle-level reference model that carries the same latencies. It also counts, directly, the edges from flag release to `fault_n` rising and compares that count with P+3 for each mode.

// File: rtl/uvs_pkg.sv
package uvs_pkg;
  localparam int N_SRC   = 4;
  localparam int SRC_VIN = 0;
  localparam int SRC_REG = 1;
  localparam int SRC_REF = 2;
  localparam int SRC_CP  = 3;

  // shutdown mask bit order: {ser, csa, cp, pwr}
  localparam int N_GATE  = 4;
  localparam int G_PWR   = 0;
  localparam int G_CP    = 1;
  localparam int G_CSA   = 2;
  localparam int G_SER   = 3;

  localparam logic [2:0] MODE_FAST = 3'b001;

  function automatic logic [N_GATE-1:0] kill_mask(input int src);
    logic [N_GATE-1:0] m;
    m = '0;
    case (src)
      SRC_VIN, SRC_REG: begin m[G_PWR] = 1'b1; m[G_SER] = 1'b1; end
      SRC_CP:           begin m[G_PWR] = 1'b1; m[G_CP]  = 1'b1; end
      SRC_REF:          m[G_CSA] = 1'b1;
      default:          m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/uvs_sync.sv
module uvs_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/uvs_retry_chan.sv
module uvs_retry_chan #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          flag,
  input  logic [CW-1:0] period,
  output logic          active
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!en) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (flag) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt >= period - CW'(1)) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !active);
  assert_flag_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (en && flag) |=> (active && cnt == '0));
  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (en && flag && active) |=> (cnt == '0));
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    !active |-> (cnt == '0));
endmodule

// File: rtl/uvs_sticky.sv
module uvs_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= (q & ~clr) | set;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (q && !clr) |=> q);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    set |=> q);
endmodule

// File: rtl/uv_supervisor.sv
module uv_supervisor #(
  parameter int FAST_CYC    = 250000,
  parameter int SLOW_CYC    = 2500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] uv_flag,
  input  logic       ref_mon_en,
  input  logic       fixed_cfg,
  input  logic [2:0] retry_mode,
  input  logic       clr_fault,
  input  logic       sleep_n,
  output logic       pwr_en,
  output logic       cp_en,
  output logic       csa_en,
  output logic       ser_en,
  output logic       fault_n,
  output logic [3:0] src_status,
  output logic       fault_sticky,
  output logic       uv_sticky
);
  import uvs_pkg::*;

  localparam int MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [N_SRC-1:0]  s_flag;
  logic [N_SRC-1:0]  chan_en;
  logic [N_SRC-1:0]  active;
  logic [CW-1:0]     period_sel;
  logic [N_GATE-1:0] kill;
  logic              sleep_q;
  logic              clear_req;
  logic              any_active;

  uvs_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(uv_flag), .q(s_flag)
  );

  always_comb begin
    if (fixed_cfg || retry_mode == MODE_FAST) period_sel = CW'(FAST_CYC);
    else                                      period_sel = CW'(SLOW_CYC);
  end

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_chan
      if (i == SRC_REF) begin : g_opt
        assign chan_en[i] = ref_mon_en & ~fixed_cfg;
      end else begin : g_fixed
        assign chan_en[i] = 1'b1;
      end
      uvs_retry_chan #(.CW(CW)) u_chan (
        .clk(clk), .rst(rst), .en(chan_en[i]), .flag(s_flag[i]),
        .period(period_sel), .active(active[i])
      );
    end
  endgenerate

  always_comb begin
    kill = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (active[i]) kill = kill | kill_mask(i);
    end
  end

  assign any_active = |active;
  assign clear_req  = clr_fault | (sleep_n & ~sleep_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_en     <= 1'b1;
      cp_en      <= 1'b1;
      csa_en     <= 1'b1;
      ser_en     <= 1'b1;
      fault_n    <= 1'b1;
      src_status <= '0;
      sleep_q    <= 1'b1;
    end else begin
      pwr_en     <= ~kill[G_PWR];
      cp_en      <= ~kill[G_CP];
      csa_en     <= ~kill[G_CSA];
      ser_en     <= ~kill[G_SER];
      fault_n    <= ~any_active;
      src_status <= active;
      sleep_q    <= sleep_n;
    end
  end

  uvs_sticky u_fault_stk (
    .clk(clk), .rst(rst), .set(any_active), .clr(clear_req), .q(fault_sticky)
  );
  uvs_sticky u_uv_stk (
    .clk(clk), .rst(rst), .set(any_active), .clr(clear_req), .q(uv_sticky)
  );

  assert_fault_pin_R5: assert property (@(posedge clk) disable iff (rst)
    any_active |=> !fault_n);
  assert_reg_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (src_status[SRC_VIN] || src_status[SRC_REG]) |-> (!pwr_en && !ser_en));
  assert_cp_gate_R4: assert property (@(posedge clk) disable iff (rst)
    src_status[SRC_CP] |-> (!pwr_en && !cp_en));
  assert_ref_gate_R4: assert property (@(posedge clk) disable iff (rst)
    src_status[SRC_REF] |-> !csa_en);
  assert_sticky_follows_R7: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> fault_sticky);
endmodule

// File: tb/sim_uv_supervisor.sv
module sim_uv_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int FAST = 12;
  localparam int SLOW = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] uv_flag = '0;
  logic       ref_mon_en = 1'b0;
  logic       fixed_cfg = 1'b0;
  logic [2:0] retry_mode = 3'b000;
  logic       clr_fault = 1'b0;
  logic       sleep_n = 1'b1;
  logic       pwr_en, cp_en, csa_en, ser_en, fault_n, fault_sticky, uv_sticky;
  logic [3:0] src_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uv_supervisor #(.FAST_CYC(FAST), .SLOW_CYC(SLOW)) u0 (
    .clk(clk), .rst(rst), .uv_flag(uv_flag), .ref_mon_en(ref_mon_en),
    .fixed_cfg(fixed_cfg), .retry_mode(retry_mode), .clr_fault(clr_fault),
    .sleep_n(sleep_n), .pwr_en(pwr_en), .cp_en(cp_en), .csa_en(csa_en),
    .ser_en(ser_en), .fault_n(fault_n), .src_status(src_status),
    .fault_sticky(fault_sticky), .uv_sticky(uv_sticky)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R8, R9: retry period from the mode field and the strap
  function automatic int exp_period(input logic [2:0] mode, input logic fx);
    if (fx || mode == 3'b001) return FAST;
    return SLOW;
  endfunction

  // R2: only the reference source can be switched off
  function automatic bit src_enabled(input int i, input logic ren, input logic fx);
    if (i == 2) return ren && !fx;
    return 1'b1;
  endfunction

  // cycle-level reference model (R11 latencies)
  logic [3:0] md1, md2, ma, e_st;
  int         mc [4];
  logic       ms_q, e_pwr, e_cp, e_csa, e_ser, e_fn, e_stk;

  always @(posedge clk) begin
    if (rst) begin
      md1 <= '0; md2 <= '0; ma <= '0; ms_q <= 1'b1;
      for (int i = 0; i < 4; i++) mc[i] <= 0;
      e_pwr <= 1; e_cp <= 1; e_csa <= 1; e_ser <= 1; e_fn <= 1;
      e_st <= '0; e_stk <= 0;
    end else begin
      md1 <= uv_flag;
      md2 <= md1;
      ms_q <= sleep_n;
      for (int i = 0; i < 4; i++) begin
        if (!src_enabled(i, ref_mon_en, fixed_cfg)) begin
          ma[i] <= 1'b0; mc[i] <= 0;
        end else if (md2[i]) begin
          ma[i] <= 1'b1; mc[i] <= 0;
        end else if (ma[i]) begin
          if (mc[i] + 1 >= exp_period(retry_mode, fixed_cfg)) begin
            ma[i] <= 1'b0; mc[i] <= 0;
          end else mc[i] <= mc[i] + 1;
        end
      end
      e_pwr <= !(ma[0] | ma[1] | ma[3]);
      e_ser <= !(ma[0] | ma[1]);
      e_cp  <= !ma[3];
      e_csa <= !ma[2];
      e_fn  <= !(|ma);
      e_st  <= ma;
      e_stk <= (e_stk & ~(clr_fault | (sleep_n & ~ms_q))) | (|ma);
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(pwr_en == e_pwr && ser_en == e_ser, "R3", "pwr/ser", {pwr_en, ser_en}, {e_pwr, e_ser});
      chk(cp_en == e_cp && csa_en == e_csa, "R4", "cp/csa", {cp_en, csa_en}, {e_cp, e_csa});
      chk(fault_n == e_fn, "R5", "fault_n", fault_n, e_fn);
      chk(src_status == e_st, "R6", "status", src_status, e_st);
      chk(fault_sticky == e_stk && uv_sticky == e_stk, "R7", "sticky",
          {fault_sticky, uv_sticky}, {e_stk, e_stk});
    end
  end

  // R8/R11: edges from flag release to fault_n rising must be P+3
  task automatic retry_time(input int src, input int p, input string req);
    int n;
    @(negedge clk); uv_flag[src] = 1'b1;
    repeat (6) @(negedge clk);
    uv_flag[src] = 1'b0;
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!fault_n && n < 500);
    chk(n == p + 3, req, "release edges", n, p + 3);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({fault_n, pwr_en, cp_en, csa_en, ser_en} == 5'b11111, "R1", "enables", {fault_n, pwr_en, cp_en, csa_en, ser_en}, 31);
    chk(src_status == 0 && !fault_sticky && !uv_sticky, "R1", "status", src_status, 0);
    cmp_on = 1'b1;

    // R11 latency: fourth edge
    uv_flag[1] = 1'b1;
    for (int e = 1; e <= 4; e++) begin
      @(posedge clk); @(negedge clk);
      chk(fault_n == (e < 4), "R11", "fault_n latency", fault_n, e < 4);
    end
    // R3 gating for regulator output
    chk(!pwr_en && !ser_en && cp_en && csa_en && src_status == 4'b0010, "R3", "reg gate", {pwr_en, ser_en, cp_en, csa_en}, 4'b0011);
    uv_flag[1] = 1'b0; idle(SLOW + 6);
    chk(fault_n && src_status == 0, "R6", "auto clear", src_status, 0);
    chk(fault_sticky && uv_sticky, "R7", "sticky held", fault_sticky, 1);
    clr_fault = 1'b1; @(negedge clk); clr_fault = 1'b0;
    chk(!fault_sticky && !uv_sticky, "R7", "clr_fault", fault_sticky, 0);

    // R4 charge pump and reference
    uv_flag[3] = 1'b1; idle(6);
    chk(!pwr_en && !cp_en && csa_en && ser_en, "R4", "cp gate", {pwr_en, cp_en, csa_en, ser_en}, 4'b0011);
    uv_flag[3] = 1'b0; idle(SLOW + 6);
    ref_mon_en = 1'b1; uv_flag[2] = 1'b1; idle(6);
    chk(!csa_en && pwr_en && cp_en && ser_en && !fault_n, "R4", "ref gate", {csa_en, pwr_en, cp_en, ser_en}, 4'b0111);
    uv_flag[2] = 1'b0; idle(SLOW + 6);
    sleep_n = 1'b0; @(negedge clk); sleep_n = 1'b1; @(negedge clk);
    chk(!fault_sticky, "R7", "sleep pulse clear", fault_sticky, 0);

    // R2 reference ignored when disabled, and under the strap (R9)
    ref_mon_en = 1'b0; uv_flag[2] = 1'b1; idle(8);
    chk(fault_n && csa_en && src_status == 0 && !fault_sticky, "R2", "ref off", {fault_n, csa_en}, 3);
    ref_mon_en = 1'b1; fixed_cfg = 1'b1; idle(8);
    chk(fault_n && csa_en && src_status == 0, "R9", "ref off strap", {fault_n, csa_en}, 3);
    uv_flag[2] = 1'b0; ref_mon_en = 1'b0; idle(4);

    // R8/R9 periods
    retry_time(3, FAST, "R9");
    fixed_cfg = 1'b0; retry_mode = 3'b000; retry_time(0, SLOW, "R8");
    retry_mode = 3'b001; retry_time(3, FAST, "R8");
    retry_mode = 3'b101; retry_time(1, SLOW, "R8");

    // R10 restart
    retry_mode = 3'b001;
    uv_flag[0] = 1'b1; idle(6); uv_flag[0] = 1'b0; idle(FAST - 2);
    uv_flag[0] = 1'b1; @(negedge clk); uv_flag[0] = 1'b0;
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!fault_n && n < 500);
    chk(n == FAST + 3, "R10", "restart edges", n, FAST + 3);

    // R7 set wins over clear while active
    uv_flag[3] = 1'b1; idle(6); clr_fault = 1'b1; @(negedge clk); clr_fault = 1'b0;
    chk(fault_sticky, "R7", "set over clear", fault_sticky, 1);
    uv_flag[3] = 1'b0; idle(SLOW + 6);

    // constrained random phase, checked by the model every cycle
    for (int c = 0; c < 6000; c++) begin
      for (int i = 0; i < 4; i++)
        if ($urandom_range(0, 24) == 0) uv_flag[i] = ~uv_flag[i];
      clr_fault = ($urandom_range(0, 49) == 0);
      if ($urandom_range(0, 79) == 0) sleep_n = 1'b0;
      else if ($urandom_range(0, 2) == 0) sleep_n = 1'b1;
      if ($urandom_range(0, 199) == 0) ref_mon_en = ~ref_mon_en;
      if ($urandom_range(0, 149) == 0) retry_mode = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 299) == 0) fixed_cfg = ~fixed_cfg;
      @(negedge clk);
    end
    uv_flag = '0; clr_fault = 1'b0; sleep_n = 1'b1; idle(SLOW + 8);
    chk(fault_n && src_status == 0, "R6", "final recovery", src_status, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule